// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital control for an 8-bit successive-approximation analog-to-digital converter inside a microcontroller. A CPU writes one control word that holds a channel number, a mode bit, a clock-divider choice and a busy/start bit. The block then divides the system clock into converter ticks and steps a fixed schedule of one reset tick, seven sample ticks, eight bit-decision ticks and one load tick. Along the way it drives the sample switch enable, the power enable of the analog macro and the trial code for the DAC array, and it reads the comparator decision back.

In single mode the block powers the converter down and drops busy once the result is stored. In continuous mode it deselects the converter for one tick and starts over. A low-power request (halt or idle) powers the converter down at once. When the request drops, a conversion that was in flight restarts from its reset tick, and the result it produces carries an invalid flag. While busy is set, a control write can only change the busy bit, so software can abort a conversion but cannot reconfigure one.

Top module: `adc_seq`

## Requirements
- R1: A conversion runs exactly 17 converter ticks: 1 reset, 7 sample, 8 bit-decision and 1 load. Busy, set by the start write, reads 1 for exactly 17×D system cycles in single mode, where D is the divide ratio.
- R2: The control word bits [3:2] select D: 0 gives 2, 1 gives 4, 2 gives 6 and 3 gives 8. Every converter phase lasts exactly D system cycles.
- R3: `samp_en` is high for exactly 7×D system cycles per conversion, covering only the sample ticks, and is low at all other times.
- R4: In single mode (control bit [1] = 0), busy clears and `adc_pwr_en` drops on the same clock edge that stores the result.
- R5: In continuous mode (control bit [1] = 1), busy stays 1. After each load, `adc_pwr_en` is low for exactly D system cycles, and then a new 17-tick conversion begins.
- R6: The trial code is resolved MSB first. In each bit tick, the bit under test is kept when `cmp_in` is 1 (input at or above `dac_code`) and cleared otherwise. The 8-bit result is written whole on the load edge and does not change at any other time.
- R7: While busy is 1, a control write changes only the busy bit (bit [0]). The channel, mode and divider fields keep their values. Writing busy to 0 aborts the conversion, drops `adc_pwr_en` and leaves the result unchanged.
- R8: While busy is 0, a single control write loads channel (bits [6:4]), divider, mode and busy together. Setting busy this way starts a conversion on the new channel, and `chan_sel` follows the channel field.
- R9: While `lp_req` is high, `adc_pwr_en` and `samp_en` are low and busy is kept. After `lp_req` drops, the conversion restarts from its reset tick, busy stays high for 17×D more cycles, and `res_invalid` reads 1 with that result.
- R10: After reset, the control readback, the result, `res_invalid`, `adc_pwr_en` and `samp_en` are all 0. A conversion with no low-power request during it sets `res_invalid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Control word: [0] busy/start, [1] continuous, [3:2] divider, [6:4] channel |
| cfg_rdata | output | 7 | Control word readback |
| res_rdata | output | 8 | Read-only conversion result |
| res_invalid | output | 1 | Result was produced after a low-power restart |
| lp_req | input | 1 | Halt or idle request |
| adc_pwr_en | output | 1 | Converter power and select enable |
| samp_en | output | 1 | Sample switch enable |
| dac_code | output | 8 | Trial code to the DAC array |
| chan_sel | output | 3 | Analog channel select |
| cmp_in | input | 1 | Comparator decision, 1 when input ≥ trial code |

## Verification
The bench builds the block with its default parameters: divider step 2, three channel bits, an 8-bit result and seven sample ticks. It runs every one of the four divider settings, so the 17×D and 7×D windows are measured at D = 2, 4, 6 and 8. It models the comparator from an ideal input voltage, which puts the all-zeros, all-ones and mid-scale codes within reach. The short divide ratio keeps the continuous, abort and low-power restart sequences to a few dozen cycles each.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RST,
    PH_SAMP,
    PH_CONV,
    PH_LOAD,
    PH_GAP
  } phase_e;

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int STEP  = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int MAX_DIV = STEP * (1 << SEL_W);
  localparam int CW      = $clog2(MAX_DIV);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim  = CW'(STEP * (int'(sel) + 1) - 1);
    tick = run && (cnt_q == lim);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= lim); // R2

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = 8,
  parameter int SAMP_CYC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             lp_req,
  input  logic             cont_mode,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             samp_en,
  output logic             pwr_en,
  output logic [RES_W-1:0] dac_code,
  output logic             load_stb,
  output logic             done
);

  localparam int SC_MAX = (SAMP_CYC > RES_W) ? SAMP_CYC : RES_W;
  localparam int SC_W   = $clog2(SC_MAX);

  phase_e           phase_q, phase_d, ph_eff;
  logic [SC_W-1:0]  sub_q, sub_d, bidx;
  logic [RES_W-1:0] trial_q, trial_d;
  logic             active;

  always_comb begin
    ph_eff   = (phase_q == PH_IDLE) ? PH_RST : phase_q;
    active   = run && !lp_req;
    bidx     = SC_W'(RES_W - 1) - sub_q;
    phase_d  = phase_q;
    sub_d    = sub_q;
    trial_d  = trial_q;
    load_stb = 1'b0;
    if (!run) begin
      phase_d = PH_IDLE;
      sub_d   = '0;
    end else if (lp_req) begin
      phase_d = PH_RST;
      sub_d   = '0;
    end else if (tick) begin
      case (ph_eff)
        PH_RST: begin
          phase_d = PH_SAMP;
          sub_d   = '0;
        end
        PH_SAMP: begin
          if (sub_q == SC_W'(SAMP_CYC - 1)) begin
            phase_d = PH_CONV;
            sub_d   = '0;
            trial_d = '0;
            trial_d[RES_W-1] = 1'b1;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        PH_CONV: begin
          trial_d[bidx] = cmp_in;
          if (bidx != '0) trial_d[bidx-1'b1] = 1'b1;
          if (sub_q == SC_W'(RES_W - 1)) begin
            phase_d = PH_LOAD;
            sub_d   = '0;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        PH_LOAD: begin
          load_stb = 1'b1;
          phase_d  = cont_mode ? PH_GAP : PH_IDLE;
        end
        PH_GAP:  phase_d = PH_RST;
        default: phase_d = PH_IDLE;
      endcase
    end
    samp_en  = active && (ph_eff == PH_SAMP);
    pwr_en   = active && (ph_eff != PH_GAP);
    done     = load_stb && !cont_mode;
    dac_code = trial_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sub_q   <= '0;
      trial_q <= '0;
    end else begin
      phase_q <= phase_d;
      sub_q   <= sub_d;
      trial_q <= trial_d;
    end
  end

  AST_LOAD_FOLLOWS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOAD && $past(phase_q) != PH_LOAD) |-> $past(phase_q) == PH_CONV); // R1
  AST_SAMP_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_en) |-> $past(ph_eff == PH_RST)); // R3
  AST_LP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run && lp_req) |=> (phase_q == PH_RST && sub_q == '0)); // R9

endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter  int PRESC_STEP = 2,
  parameter  int CH_W       = 3,
  parameter  int RES_W      = 8,
  parameter  int SAMP_CYC   = 7,
  localparam int CFG_W      = CH_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [RES_W-1:0] res_rdata,
  output logic             res_invalid,
  input  logic             lp_req,
  output logic             adc_pwr_en,
  output logic             samp_en,
  output logic [RES_W-1:0] dac_code,
  output logic [CH_W-1:0]  chan_sel,
  input  logic             cmp_in
);

  logic             busy_q, busy_d, mode_q, mode_d;
  logic [1:0]       presc_q, presc_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             inv_q, inv_d, taint_q, taint_d;
  logic             tick, load_stb, done;

  adc_seq_clkdiv #(.STEP(PRESC_STEP), .SEL_W(2)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q && !lp_req),
    .sel  (presc_q),
    .tick (tick)
  );

  adc_seq_ctrl #(.RES_W(RES_W), .SAMP_CYC(SAMP_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .lp_req   (lp_req),
    .cont_mode(mode_q),
    .tick     (tick),
    .cmp_in   (cmp_in),
    .samp_en  (samp_en),
    .pwr_en   (adc_pwr_en),
    .dac_code (dac_code),
    .load_stb (load_stb),
    .done     (done)
  );

  always_comb begin
    busy_d  = busy_q;
    mode_d  = mode_q;
    presc_d = presc_q;
    chan_d  = chan_q;
    if (cfg_wr) begin
      busy_d = cfg_wdata[0];
      if (!busy_q) begin
        mode_d  = cfg_wdata[1];
        presc_d = cfg_wdata[3:2];
        chan_d  = cfg_wdata[CFG_W-1:4];
      end
    end else if (done) begin
      busy_d = 1'b0;
    end
    res_d = load_stb ? dac_code : res_q;
    inv_d = load_stb ? taint_q  : inv_q;
    if (!busy_q)      taint_d = 1'b0;
    else if (lp_req)  taint_d = 1'b1;
    else if (load_stb) taint_d = 1'b0;
    else              taint_d = taint_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      mode_q  <= 1'b0;
      presc_q <= '0;
      chan_q  <= '0;
      res_q   <= '0;
      inv_q   <= 1'b0;
      taint_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      mode_q  <= mode_d;
      presc_q <= presc_d;
      chan_q  <= chan_d;
      taint_q <= taint_d;
      if (load_stb) begin
        res_q <= res_d;
        inv_q <= inv_d;
      end
    end
  end

  assign cfg_rdata   = {chan_q, presc_q, mode_q, busy_q};
  assign res_rdata   = res_q;
  assign res_invalid = inv_q;
  assign chan_sel    = chan_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cfg_wr) |=> ($stable(mode_q) && $stable(presc_q) && $stable(chan_q))); // R7
  AST_RES_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $past(load_stb)); // R6
  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_wr) |=> !busy_q); // R4
  AST_LP_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_req && busy_q) |=> busy_q || $past(cfg_wr)); // R9

endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic [6:0] cfg_rdata;
  logic [7:0] res_rdata, dac_code;
  logic       res_invalid, adc_pwr_en, samp_en, cmp_in;
  logic       lp_req = 1'b0;
  logic [2:0] chan_sel;
  logic [7:0] vin = '0;
  int         checks = 0;
  int         fails = 0;
  int         cyc = 0;

  always #4 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  adc_seq u_adc_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .res_rdata(res_rdata), .res_invalid(res_invalid),
    .lp_req(lp_req), .adc_pwr_en(adc_pwr_en), .samp_en(samp_en),
    .dac_code(dac_code), .chan_sel(chan_sel), .cmp_in(cmp_in)
  );

  // presc[12:11], chan[10:8], vin[7:0]
  localparam logic [12:0] VEC [0:5] = '{
    {2'd0, 3'd1, 8'h00},
    {2'd1, 3'd2, 8'hFF},
    {2'd2, 3'd3, 8'hA5},
    {2'd3, 3'd4, 8'h5A},
    {2'd0, 3'd7, 8'h80},
    {2'd2, 3'd0, 8'h7F}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [6:0] w);
    @(negedge clk);
    cfg_wdata = w;
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic busy_window(output int nb, output int ns);
    nb = 0;
    ns = 0;
    while (cfg_rdata[0] && nb < 5000) begin
      nb++;
      if (samp_en) ns++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int nb, ns, d;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cfg_rdata == 0 && res_rdata == 0 && !res_invalid && !adc_pwr_en && !samp_en,
        "R10", int'(cfg_rdata) + int'(res_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      d   = 2 * (int'(VEC[i][12:11]) + 1);
      vin = VEC[i][7:0];
      wr_cfg({VEC[i][10:8], VEC[i][12:11], 1'b0, 1'b1});
      chk(chan_sel == VEC[i][10:8], "R8", int'(chan_sel), int'(VEC[i][10:8]));
      busy_window(nb, ns);
      chk(nb == 17 * d, "R1 R2", nb, 17 * d);
      chk(ns == 7 * d, "R3", ns, 7 * d);
      chk(res_rdata == VEC[i][7:0], "R6", int'(res_rdata), int'(VEC[i][7:0]));
      chk(!adc_pwr_en, "R4", int'(adc_pwr_en), 0);
      chk(!res_invalid, "R10", int'(res_invalid), 0);
    end

    // R7 write protection while busy
    vin = 8'h10;
    wr_cfg({3'd2, 2'd3, 1'b0, 1'b1});
    repeat (5) @(negedge clk);
    wr_cfg({3'd5, 2'd0, 1'b1, 1'b1});
    chk(cfg_rdata == {3'd2, 2'd3, 1'b0, 1'b1}, "R7", int'(cfg_rdata), int'({3'd2, 2'd3, 1'b0, 1'b1}));
    busy_window(nb, ns);
    chk(res_rdata == 8'h10, "R7", int'(res_rdata), 16);

    // R5 continuous mode, D = 2
    vin = 8'h5A;
    wr_cfg({3'd1, 2'd0, 1'b1, 1'b1});
    nb = 0;
    while (adc_pwr_en && nb < 5000) begin nb++; @(negedge clk); end
    chk(nb == 34, "R5", nb, 34);
    chk(res_rdata == 8'h5A, "R5", int'(res_rdata), 90);
    vin = 8'h33;
    nb = 0;
    while (!adc_pwr_en && nb < 5000) begin nb++; @(negedge clk); end
    chk(nb == 2 && cfg_rdata[0], "R5", nb, 2);
    nb = 0;
    while (adc_pwr_en && nb < 5000) begin nb++; @(negedge clk); end
    chk(nb == 34 && res_rdata == 8'h33, "R5", int'(res_rdata), 51);
    // R7 abort keeps fields and result
    vin = 8'h99;
    repeat (6) @(negedge clk);
    wr_cfg(7'd0);
    chk(!cfg_rdata[0] && cfg_rdata[1] && !adc_pwr_en, "R7", int'(cfg_rdata), 3);
    repeat (40) @(negedge clk);
    chk(res_rdata == 8'h33, "R7", int'(res_rdata), 51);

    // R9 low-power restart
    vin = 8'h77;
    wr_cfg({3'd0, 2'd0, 1'b0, 1'b1});
    repeat (20) @(negedge clk);
    lp_req = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!adc_pwr_en && !samp_en && cfg_rdata[0], "R9", int'(adc_pwr_en), 0);
    end
    lp_req = 1'b0;
    busy_window(nb, ns);
    chk(nb == 34, "R9", nb, 34);
    chk(res_invalid && res_rdata == 8'h77, "R9", int'(res_invalid), 1);
    vin = 8'h21;
    wr_cfg({3'd0, 2'd0, 1'b0, 1'b1});
    busy_window(nb, ns);
    chk(!res_invalid && res_rdata == 8'h21, "R10", int'(res_invalid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule